// File: doc/BRIEF.md
# Pipelined Quadrature Sine/Cosine Generator with Dynamic Micro-Rotations

This block turns an unsigned phase word into a pair of signed samples: I carries the cosine and Q the sine of that phase. It is meant to sit behind a phase or frequency accumulator in a digital synthesizer, where a new phase arrives every clock. No multipliers are used. The sample pair is built by a chain of shift-and-add vector rotations, the coordinate rotation method in rotation mode. Each stage of the chain is one register stage, so a new phase can be accepted on every clock.

The two top phase bits pick a quadrant. The remaining bits form an angle in the first quadrant, and the rotation chain drives that angle toward zero. The early stages rotate by fixed angles with fixed shifts. The later stages look at the angle that is still left over and choose the table angle nearest to it. They may choose only from indices larger than any index already applied. The chosen index sets a barrel shift on both data paths. In those later stages the length change per rotation is smaller than one output LSB. The overall gain is therefore a single constant, and it is removed in advance through the starting X value.

At the end of the chain, the quadrant bits swap and negate the two results. The results are then rounded and clipped to the output width. A valid bit travels with the data through every stage.

Top module: `phase_sincos_pdr`

## Requirements
- R1: While reset is asserted, and until a phase has been accepted after reset, out_valid is 0. A phase presented during reset produces no output.
- R2: Every accepted phase (in_valid = 1 at a rising clock edge) produces exactly one result. That result has out_valid = 1 exactly N_STATIC + N_DYN + 1 cycles later (14 with the defaults). Results come out in order, one per cycle at full rate, and gaps in the input stay gaps in the output.
- R3: out_i is within 3 LSB of round(2046 * cos(2*pi*p/2^16)) for any 16-bit phase p.
- R4: out_q is within 3 LSB of round(2046 * sin(2*pi*p/2^16)) for any 16-bit phase p.
- R5: Bits [15:14] of the phase select the quadrant: 0 gives (+cos, +sin), 1 gives (-sin, +cos), 2 gives (-cos, -sin) and 3 gives (+sin, -cos), each applied to the first-quadrant angle in bits [13:0]. Away from the axes, the signs of I and Q match the signs of the true cosine and sine.
- R6: The gain is constant. sqrt(I^2 + Q^2) is within 3 LSB of 2046 for every phase, and |I| + |Q| lies between 2040 and 3069.
- R7: Neither output ever takes the most negative code (-2048). Results are clipped to +/-2047.
- R8: A result depends only on its own phase. The same phase gives the same I and Q whether it is presented alone or inside a back-to-back stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Phase word is valid this cycle |
| in_phase | input | PH_W (16) | Unsigned phase, full scale is one turn |
| out_valid | output | 1 | I/Q pair is valid this cycle |
| out_i | output | OUT_W (12) | Signed cosine sample, two's complement |
| out_q | output | OUT_W (12) | Signed sine sample, two's complement |

## Verification
The generator is driven in several ways:
- Exact axis phases (0, a quarter, a half and three quarters of a turn) check the quadrant swap and the negation. There the nonzero output must reach full amplitude while the other output sits at zero.
- Phases next to the quadrant edges (0x0001, 0x3FFF, 0x7FFF, 0xFFFF), the diagonals and irregular values exercise the dynamic stages, which are where the residual-angle selection matters. The magnitude check on all of these would expose a gain that drifts when the set of chosen indices changes.
- Back-to-back streams, streams with gaps, and a repeated phase set apart from a stream separate the latency and ordering behaviour from any leakage between neighbouring samples.

// File: rtl/phase_sincos_pdr.sv
`timescale 1ns/1ps
module phase_sincos_pdr #(
  parameter int PH_W     = 16,
  parameter int OUT_W    = 12,
  parameter int N_STATIC = 8,
  parameter int N_DYN    = 5,
  parameter int GUARD    = 4,
  parameter int XF       = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PH_W-1:0]         in_phase,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int ZW   = PH_W + GUARD;
  localparam int XW   = OUT_W + XF + 1;
  localparam int NST  = N_STATIC + N_DYN;
  localparam int JMAX = ZW - 3;
  localparam int JW   = $clog2(JMAX + 2);
  localparam int AMP  = 2**(OUT_W-1) - 2;
  localparam int SMAX = 2**(OUT_W-1) - 1;

  function automatic logic signed [ZW-1:0] atan_bam(input int j);
    real a;
    a = $atan(2.0 ** (-j)) / 6.283185307179586 * (2.0 ** ZW);
    return ZW'($rtoi(a + 0.5));
  endfunction

  function automatic int start_x();
    real g;
    g = 1.0;
    for (int j = 0; j < N_STATIC; j++) g = g * $sqrt(1.0 + 2.0 ** (-2 * j));
    return $rtoi(AMP * (2.0 ** XF) / g + 0.5);
  endfunction

  function automatic logic signed [OUT_W-1:0] to_out(input logic signed [XW:0] v);
    logic signed [XW:0] t;
    t = (v + (XW+1)'(2**(XF-1))) >>> XF;
    if (t > (XW+1)'(SMAX)) return OUT_W'(SMAX);
    if (t < (XW+1)'(-SMAX)) return OUT_W'(-SMAX);
    return t[OUT_W-1:0];
  endfunction

  localparam logic signed [XW-1:0] X0 = XW'(start_x());

  logic signed [ZW-1:0] ang [0:JMAX+1];
  logic [ZW-1:0]        mid [N_STATIC:JMAX];

  for (genvar k = 0; k <= JMAX + 1; k++) begin : g_ang
    assign ang[k] = atan_bam(k);
  end
  for (genvar k = N_STATIC; k <= JMAX; k++) begin : g_mid
    assign mid[k] = ZW'((ang[k] + ang[k+1]) >>> 1);
  end

  logic signed [XW-1:0] xs [1:NST];
  logic signed [XW-1:0] ys [1:NST];
  logic signed [ZW-1:0] zs [1:NST];
  logic [1:0]           qs [1:NST];
  logic [JW-1:0]        js [1:NST];
  logic                 vs [1:NST];

  for (genvar i = 0; i < NST; i++) begin : g_stage
    logic signed [XW-1:0] xi, yi, xn, yn;
    logic signed [ZW-1:0] zi, zn, da;
    logic [1:0]           qi;
    logic [JW-1:0]        ji, jn, sh;
    logic                 vi, rot;

    if (i == 0) begin : g_head
      assign xi = X0;
      assign yi = '0;
      assign zi = {2'b00, in_phase[PH_W-3:0], {GUARD{1'b0}}};
      assign qi = in_phase[PH_W-1 -: 2];
      assign ji = JW'(N_STATIC - 1);
      assign vi = in_valid;
    end else begin : g_link
      assign xi = xs[i];
      assign yi = ys[i];
      assign zi = zs[i];
      assign qi = qs[i];
      assign ji = js[i];
      assign vi = vs[i];
    end

    if (i < N_STATIC) begin : g_fixed
      assign sh  = JW'(i);
      assign rot = 1'b1;
      assign jn  = ji;
    end else begin : g_dyn
      logic [ZW-1:0] mag;
      logic [JW-1:0] pick;
      logic          hit;
      always_comb begin
        mag  = zi[ZW-1] ? ZW'(-zi) : ZW'(zi);
        pick = ji;
        hit  = 1'b0;
        for (int k = JMAX; k >= N_STATIC; k--) begin
          if (k > int'(ji) && mag >= mid[k]) begin
            pick = JW'(k);
            hit  = 1'b1;
          end
        end
      end
      assign sh  = pick;
      assign rot = hit;
      assign jn  = pick;
    end

    assign da = ang[sh];

    always_comb begin
      xn = xi;
      yn = yi;
      zn = zi;
      if (rot) begin
        if (zi[ZW-1]) begin
          xn = xi + (yi >>> sh);
          yn = yi - (xi >>> sh);
          zn = zi + da;
        end else begin
          xn = xi - (yi >>> sh);
          yn = yi + (xi >>> sh);
          zn = zi - da;
        end
      end
    end

    always_ff @(posedge clk) begin
      xs[i+1] <= xn;
      ys[i+1] <= yn;
      zs[i+1] <= zn;
      qs[i+1] <= qi;
      js[i+1] <= jn;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) vs[i+1] <= 1'b0;
      else        vs[i+1] <= vi;
  end

  logic signed [XW:0] xe, ye, cv, sv;
  assign xe = (XW+1)'(xs[NST]);
  assign ye = (XW+1)'(ys[NST]);

  always_comb begin
    unique case (qs[NST])
      2'd0:    begin cv =  xe; sv =  ye; end
      2'd1:    begin cv = -ye; sv =  xe; end
      2'd2:    begin cv = -xe; sv = -ye; end
      default: begin cv =  ye; sv = -xe; end
    endcase
  end

  always_ff @(posedge clk) begin
    out_i <= to_out(cv);
    out_q <= to_out(sv);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vs[NST];
endmodule

// File: rtl/phase_sincos_pdr_chk.sv
`timescale 1ns/1ps
module phase_sincos_pdr_chk #(
  parameter int LAT   = 14,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);
  localparam int AMP = 2**(OUT_W-1) - 2;
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic int mag1(input logic signed [OUT_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  logic [LAT-1:0] vsh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vsh <= '0;
    else        vsh <= {vsh[LAT-2:0], in_valid};

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_fixed_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LAT-1]);

  p_const_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mag1(out_i) + mag1(out_q) >= AMP - 6) &&
                  (mag1(out_i) + mag1(out_q) <= (AMP * 3) / 2));

  p_no_most_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != MOST_NEG) && (out_q != MOST_NEG));
endmodule

bind phase_sincos_pdr phase_sincos_pdr_chk #(
  .LAT(N_STATIC + N_DYN + 1), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/phase_sincos_pdr_tb_top.sv
`timescale 1ns/1ps
module phase_sincos_pdr_tb_top;
  localparam int LAT = 14;
  localparam int AMP = 2046;
  localparam int TOL = 3;
  localparam int NV  = 16;
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'h0000, 16'h4000, 16'h8000, 16'hC000,
    16'h2000, 16'h6000, 16'hA000, 16'hE000,
    16'h0001, 16'h3FFF, 16'h7FFF, 16'hFFFF,
    16'h1555, 16'h5A5A, 16'h9249, 16'hD00D};

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [15:0] in_phase;
  logic out_valid;
  logic signed [11:0] out_i, out_q;

  phase_sincos_pdr dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int wr = 0, rd = 0;
  bit done = 1'b0;
  logic [15:0] sent [0:1023];
  int got_i [0:1023];
  int got_q [0:1023];

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction
  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction
  function automatic int exp_cos(input logic [15:0] p);
    return rnd(AMP * $cos(6.283185307179586 * p / 65536.0));
  endfunction
  function automatic int exp_sin(input logic [15:0] p);
    return rnd(AMP * $sin(6.283185307179586 * p / 65536.0));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (rd >= wr) begin
        check(1'b0, "R2 output without input", rd, wr);
      end else begin
        int ec, es, ai, aq, m;
        ec = exp_cos(sent[rd]);
        es = exp_sin(sent[rd]);
        ai = int'(out_i);
        aq = int'(out_q);
        got_i[rd] = ai;
        got_q[rd] = aq;
        check(iabs(ai - ec) <= TOL, "R3 cosine", ai, ec);
        check(iabs(aq - es) <= TOL, "R4 sine", aq, es);
        m = rnd($sqrt(real'(ai * ai + aq * aq)));
        check(iabs(m - AMP) <= TOL, "R6 magnitude", m, AMP);
        check(ai != -2048 && aq != -2048, "R7 clip", (ai < aq) ? ai : aq, -2047);
        if (iabs(ec) > TOL) check((ai < 0) == (ec < 0), "R5 I sign", ai, ec);
        if (iabs(es) > TOL) check((aq < 0) == (es < 0), "R5 Q sign", aq, es);
        rd++;
      end
    end
  end

  task automatic send(input logic [15:0] p);
    in_phase = p;
    in_valid = 1'b1;
    sent[wr] = p;
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", rd, wr);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt, a, b;
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_phase = 16'h1234;
    repeat (5) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT + 3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid low after reset", int'(out_valid), 0);
    end

    // R2: single phase, count cycles to its result
    in_phase = VEC[4];
    in_valid = 1'b1;
    sent[wr] = VEC[4];
    wr++;
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == LAT, "R2 latency", cnt, LAT);
    idle(LAT + 2);

    // table walk, back to back (R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) send(VEC[i]);
    idle(LAT + 2);

    // same table with gaps (R2)
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      idle(i % 3);
    end
    idle(LAT + 2);
    check(rd == wr, "R2 one result per input with gaps", rd, wr);

    // sweep over the circle (R3 R4)
    for (int i = 0; i < 64; i++) send(16'(i * 16'h0400 + 16'h0123));
    idle(LAT + 2);

    // R8: isolated versus inside a stream
    a = wr;
    send(16'h2AAA);
    idle(LAT + 2);
    send(VEC[0]);
    send(VEC[9]);
    send(VEC[11]);
    b = wr;
    send(16'h2AAA);
    send(VEC[5]);
    idle(LAT + 2);
    check(got_i[a] == got_i[b], "R8 I isolated vs streamed", got_i[b], got_i[a]);
    check(got_q[a] == got_q[b], "R8 Q isolated vs streamed", got_q[b], got_q[a]);

    check(rd == wr, "R2 all inputs answered", rd, wr);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule